// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block sits on the processor side of a vectored interrupt controller. At one sample point per instruction it looks at the interrupt the controller presents: a vector number, a priority level and a register shadow-set number. It compares that priority with the processor's current priority level. When it takes the interrupt, it saves the current program counter in an exception return register and raises an exception-level flag, which masks any further interrupt. It also raises the current priority to the one it took, switches to the requested shadow set, and issues a one-cycle redirect to the handler address.

The handler address depends on the vectoring mode. In the common-entry mode every interrupt goes to the base address. In the per-vector mode the address is the base plus the vector number times a selectable spacing of 32, 64, 128 or 256 bytes. A return strobe redirects control back to the saved program counter. It also clears the exception level and puts back the priority and shadow set that were active before entry. Software can clear the exception-level flag on its own, which re-opens the unit to interrupts of a strictly higher priority.

The control is a two-state machine. `ST_RUN` is normal execution with interrupts open, and `ST_HANDLER` is execution with the exception level set. It has these transitions:
- `T_ENTER` (ST_RUN to ST_HANDLER) when an interrupt is taken.
- `T_RETURN` (either state to ST_RUN) on the return strobe.
- `T_SWCLEAR` (ST_HANDLER to ST_RUN) when software clears the flag.
- `T_HOLD` in all other cases.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, `exl` is 0, `cur_level` is 0, `active_shadow` is 0, `epc` is 0 and `redirect_valid` is 0.
- R2: An interrupt is taken only in a cycle where all of these hold: `sample_en` and `req_valid` are 1, `exl` is 0, `eret` is 0, and `req_level` is strictly greater than `cur_level`. In any other cycle no state changes and no entry redirect is issued.
- R3: When an interrupt is taken, the next cycle shows `exl` = 1, `epc` equal to the `cur_pc` value of the taking cycle, and `redirect_valid` = 1 for one cycle.
- R4: When an interrupt is taken, `cur_level` becomes `req_level` and `active_shadow` becomes `req_shadow`. The previous level and shadow set are kept for the return.
- R5: With `multi_vector` = 0, every taken interrupt redirects to `vec_base`.
- R6: With `multi_vector` = 1, the redirect address is `vec_base + req_vector * (32 << spacing_sel)`. The `spacing_sel` encoding is 0 for 32 bytes, 1 for 64, 2 for 128 and 3 for 256.
- R7: While `exl` is 1, no interrupt is taken. A pulse on `exl_clear` clears `exl` only: `cur_level`, `active_shadow` and `epc` keep their values.
- R8: A pulse on `eret` gives, in the next cycle, `redirect_valid` = 1 with `redirect_pc` equal to `epc`, `exl` = 0, and the pre-entry level and shadow set restored.
- R9: When `eret` and a takeable request fall in the same cycle, the return is carried out and the request is not taken. A request still presented at the next sample point is evaluated against the restored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Per-instruction sample point |
| req_valid | input | 1 | An interrupt is presented |
| req_vector | input | 6 | Presented vector number |
| req_level | input | 3 | Presented priority level |
| req_shadow | input | 4 | Presented shadow-set number |
| cur_pc | input | 32 | Program counter of the sampled instruction |
| multi_vector | input | 1 | 1 = per-vector addresses, 0 = common entry |
| spacing_sel | input | 2 | Vector spacing select |
| vec_base | input | 32 | Vector base address |
| exl_clear | input | 1 | Software clear of the exception level |
| eret | input | 1 | Exception return strobe |
| redirect_valid | output | 1 | One-cycle redirect request |
| redirect_pc | output | 32 | Redirect target |
| epc | output | 32 | Saved return address |
| exl | output | 1 | Exception level (interrupts masked) |
| cur_level | output | 3 | Current processor priority level |
| active_shadow | output | 4 | Active register shadow set |

## Verification
The vector walk starts each case from reset. It covers both vectoring modes, all four spacings, the lowest and highest vector numbers, and a level-0 request. Together these cases separate the common-entry address from the computed one, show that a wrong shift amount gives a wrong address, and show that a request at the reset level is refused by the strict comparison. The directed sequence covers four situations. A request equal to the current level after a software clear separates `>` from `>=`. A masked request during the handler shows the effect of the exception-level gate. A return coinciding with a higher request shows the ordering rule. A second entry and return show that the one-deep level and shadow save is restored.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } acc_state_t;
endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int LVL_W = 3
) (
    input  logic             sample_en,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             masked,
    input  logic             ret_now,
    output logic             take
);
    // strict comparison; a return in the same cycle wins
    always_comb begin
        take = sample_en && req_valid && !masked && !ret_now
               && (req_level > cur_level);
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 6
) (
    input  logic              multi_vector,
    input  logic [1:0]        spacing_sel,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [VEC_W-1:0]  vector,
    output logic [ADDR_W-1:0] target
);
    localparam int MIN_SHIFT = 5;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(vector) << (MIN_SHIFT + int'(spacing_sel));
        target = multi_vector ? (vec_base + offset) : vec_base;
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 6,
    parameter int LVL_W  = 3,
    parameter int SS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [SS_W-1:0]   req_shadow,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              multi_vector,
    input  logic [1:0]        spacing_sel,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic              exl_clear,
    input  logic              eret,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] epc,
    output logic              exl,
    output logic [LVL_W-1:0]  cur_level,
    output logic [SS_W-1:0]   active_shadow
);
    import irq_accept_pkg::*;

    acc_state_t        state_q, state_d;
    logic              take;
    logic [ADDR_W-1:0] entry_addr;
    logic [LVL_W-1:0]  saved_level;
    logic [SS_W-1:0]   saved_shadow;

    assign exl = (state_q == ST_HANDLER);

    irq_prio_gate #(.LVL_W(LVL_W)) i_gate (
        .sample_en (sample_en),
        .req_valid (req_valid),
        .req_level (req_level),
        .cur_level (cur_level),
        .masked    (exl),
        .ret_now   (eret),
        .take      (take)
    );

    irq_vec_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_addr (
        .multi_vector (multi_vector),
        .spacing_sel  (spacing_sel),
        .vec_base     (vec_base),
        .vector       (req_vector),
        .target       (entry_addr)
    );

    // next state: T_ENTER, T_RETURN, T_SWCLEAR, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take) state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (eret || exl_clear) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // context and redirect outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            epc            <= '0;
            cur_level      <= '0;
            active_shadow  <= '0;
            saved_level    <= '0;
            saved_shadow   <= '0;
        end else begin
            redirect_valid <= 1'b0;
            if (eret) begin
                redirect_valid <= 1'b1;
                redirect_pc    <= epc;
                cur_level      <= saved_level;
                active_shadow  <= saved_shadow;
            end else if (take) begin
                redirect_valid <= 1'b1;
                redirect_pc    <= entry_addr;
                epc            <= cur_pc;
                saved_level    <= cur_level;
                saved_shadow   <= active_shadow;
                cur_level      <= req_level;
                active_shadow  <= req_shadow;
            end
        end
    end
endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 3,
    parameter int SS_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic              req_valid,
    input logic [LVL_W-1:0]  req_level,
    input logic [SS_W-1:0]   req_shadow,
    input logic [ADDR_W-1:0] cur_pc,
    input logic              eret,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [ADDR_W-1:0] epc,
    input logic              exl,
    input logic [LVL_W-1:0]  cur_level,
    input logic [SS_W-1:0]   active_shadow
);
    // R2
    refuse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && req_valid && !exl && !eret && req_level <= cur_level)
        |=> (!redirect_valid && !exl && $stable(epc)));

    // R3
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && req_valid && !exl && !eret && req_level > cur_level)
        |=> (redirect_valid && exl && epc == $past(cur_pc)));

    // R4
    entry_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && req_valid && !exl && !eret && req_level > cur_level)
        |=> (cur_level == $past(req_level) && active_shadow == $past(req_shadow)));

    // R7
    masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exl && !eret) |=> !redirect_valid);

    // R8
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eret |=> (redirect_valid && !exl && redirect_pc == $past(epc)));
endmodule

bind irq_accept_unit irq_accept_unit_chk #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .SS_W(SS_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_en      (sample_en),
    .req_valid      (req_valid),
    .req_level      (req_level),
    .req_shadow     (req_shadow),
    .cur_pc         (cur_pc),
    .eret           (eret),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .exl            (exl),
    .cur_level      (cur_level),
    .active_shadow  (active_shadow)
);

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_en, req_valid, multi_vector, exl_clear, eret;
    logic [5:0]  req_vector;
    logic [2:0]  req_level;
    logic [3:0]  req_shadow;
    logic [31:0] cur_pc, vec_base;
    logic [1:0]  spacing_sel;
    logic        redirect_valid, exl;
    logic [31:0] redirect_pc, epc;
    logic [2:0]  cur_level;
    logic [3:0]  active_shadow;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .req_valid(req_valid),
        .req_vector(req_vector), .req_level(req_level), .req_shadow(req_shadow),
        .cur_pc(cur_pc), .multi_vector(multi_vector), .spacing_sel(spacing_sel),
        .vec_base(vec_base), .exl_clear(exl_clear), .eret(eret),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc(epc),
        .exl(exl), .cur_level(cur_level), .active_shadow(active_shadow)
    );

    typedef struct packed {
        logic        multi;
        logic [1:0]  sel;
        logic [31:0] base;
        logic [5:0]  vec;
        logic [2:0]  lvl;
        logic [3:0]  sh;
        logic [31:0] pc;
        logic        acc;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 32'h9D000000, 6'd5,  3'd2, 4'd1, 32'h00000100, 1'b1, 32'h9D000000},
        '{1'b1, 2'd0, 32'h9D000000, 6'd5,  3'd2, 4'd1, 32'h00000104, 1'b1, 32'h9D0000A0},
        '{1'b1, 2'd1, 32'h9D000000, 6'd3,  3'd7, 4'd7, 32'h00000108, 1'b1, 32'h9D0000C0},
        '{1'b1, 2'd2, 32'h9D000000, 6'd10, 3'd1, 4'd2, 32'h0000010C, 1'b1, 32'h9D000500},
        '{1'b1, 2'd3, 32'h9D000000, 6'd63, 3'd4, 4'd3, 32'h00000110, 1'b1, 32'h9D003F00},
        '{1'b1, 2'd3, 32'h00001000, 6'd0,  3'd1, 4'd4, 32'h00000114, 1'b1, 32'h00001000},
        '{1'b1, 2'd0, 32'h9D000000, 6'd9,  3'd0, 4'd5, 32'h00000118, 1'b0, 32'h00000000},
        '{1'b0, 2'd2, 32'h80001200, 6'd63, 3'd7, 4'd6, 32'h0000011C, 1'b1, 32'h80001200}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sample_en = 0; req_valid = 0; exl_clear = 0; eret = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic present(input logic [5:0] v, input logic [2:0] l,
                           input logic [3:0] s, input logic [31:0] pc);
        sample_en = 1; req_valid = 1;
        req_vector = v; req_level = l; req_shadow = s; cur_pc = pc;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        multi_vector = 0; spacing_sel = 0; vec_base = 0;
        req_vector = 0; req_level = 0; req_shadow = 0; cur_pc = 0;
        do_reset();
        // R1 reset state
        chk("R1 exl", 32'(exl), 0);
        chk("R1 level", 32'(cur_level), 0);
        chk("R1 shadow", 32'(active_shadow), 0);
        chk("R1 epc", epc, 0);
        chk("R1 redirect", 32'(redirect_valid), 0);

        // vector walk: R5, R6, R3, R4, R2
        for (int i = 0; i < NV; i++) begin
            do_reset();
            multi_vector = TBL[i].multi; spacing_sel = TBL[i].sel; vec_base = TBL[i].base;
            present(TBL[i].vec, TBL[i].lvl, TBL[i].sh, TBL[i].pc);
            @(negedge clk);
            idle_inputs();
            chk("R2/R3 redirect_valid", 32'(redirect_valid), 32'(TBL[i].acc));
            chk("R3 exl", 32'(exl), 32'(TBL[i].acc));
            chk("R3 epc", epc, TBL[i].acc ? TBL[i].pc : 32'h0);
            chk("R4 level", 32'(cur_level), TBL[i].acc ? 32'(TBL[i].lvl) : 32'h0);
            chk("R4 shadow", 32'(active_shadow), TBL[i].acc ? 32'(TBL[i].sh) : 32'h0);
            if (TBL[i].acc)
                chk(TBL[i].multi ? "R6 target" : "R5 target", redirect_pc, TBL[i].tgt);
        end

        // directed sequence
        do_reset();
        multi_vector = 1; spacing_sel = 0; vec_base = 0;
        // R2: no sample point, no entry
        sample_en = 0; req_valid = 1; req_level = 5; req_vector = 1; cur_pc = 32'h10;
        @(negedge clk);
        chk("R2 no sample", 32'(redirect_valid), 0);
        chk("R2 no sample exl", 32'(exl), 0);
        // entry at level 3
        present(6'd2, 3'd3, 4'd2, 32'h40);
        @(negedge clk);
        idle_inputs();
        chk("R6 target", redirect_pc, 32'h40);
        chk("R3 epc", epc, 32'h40);
        chk("R4 level", 32'(cur_level), 3);
        // R7 masked while exl
        present(6'd4, 3'd6, 4'd6, 32'h80);
        @(negedge clk);
        idle_inputs();
        chk("R7 masked", 32'(redirect_valid), 0);
        chk("R7 epc kept", epc, 32'h40);
        // R7 software clear
        exl_clear = 1;
        @(negedge clk);
        idle_inputs();
        chk("R7 clear exl", 32'(exl), 0);
        chk("R7 level kept", 32'(cur_level), 3);
        chk("R7 shadow kept", 32'(active_shadow), 2);
        // R2 equal level refused
        present(6'd1, 3'd3, 4'd5, 32'h200);
        @(negedge clk);
        idle_inputs();
        chk("R2 equal level", 32'(redirect_valid), 0);
        chk("R2 equal exl", 32'(exl), 0);
        // nested entry at level 5
        present(6'd1, 3'd5, 4'd5, 32'h200);
        @(negedge clk);
        idle_inputs();
        chk("R6 nested target", redirect_pc, 32'h20);
        chk("R3 nested epc", epc, 32'h200);
        // R9 return with a level-7 request in the same cycle
        present(6'd4, 3'd7, 4'd6, 32'h300);
        eret = 1;
        @(negedge clk);
        eret = 0;
        chk("R9 return target", redirect_pc, 32'h200);
        chk("R9 exl", 32'(exl), 0);
        chk("R8 level restored", 32'(cur_level), 3);
        chk("R8 shadow restored", 32'(active_shadow), 2);
        // R9 request still present, taken now
        @(negedge clk);
        idle_inputs();
        chk("R9 deferred take", 32'(redirect_valid), 1);
        chk("R9 deferred target", redirect_pc, 32'h80);
        chk("R9 level", 32'(cur_level), 7);
        // R8 return
        eret = 1;
        @(negedge clk);
        eret = 0;
        chk("R8 redirect", 32'(redirect_valid), 1);
        chk("R8 target", redirect_pc, 32'h300);
        chk("R8 exl", 32'(exl), 0);
        chk("R8 level", 32'(cur_level), 3);
        chk("R8 shadow", 32'(active_shadow), 2);
        @(negedge clk);
        chk("R3 one-cycle pulse", 32'(redirect_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule